// File: doc/BRIEF.md
# Second Operand Shifter

This combinational unit forms the second operand, together with a carry-out, for a 32-bit data-processing datapath. It has three operand modes. The first builds a constant by rotating an 8-bit value right by an even amount. The second passes a register value through unchanged. The third sends a register value through a shifter that can do logical left, logical right, arithmetic right, rotate right, or a one-bit rotate through the carry flag.

In the shifted mode the shift amount comes from one of two places: a 5-bit immediate field, or the low byte of a second register. The carry-out is the last bit moved out of the word. When nothing moves, the carry-out is the incoming carry flag. A downstream ALU uses the operand and may use the carry when it updates its flags. Decode, the register file and the ALU are outside this unit.

Top module: `opnd_shifter`

## Requirements
- R1: With `op_mode` = 0, `operand_out` is `imm_val`, zero-extended to 32 bits and rotated right by 2×`imm_rot`. `carry_out` is `carry_in` when `imm_rot` = 0, and `operand_out[31]` otherwise.
- R2: With `op_mode` = 1 or 3, `operand_out` equals `rm_val` and `carry_out` equals `carry_in`.
- R3: With `op_mode` = 2 and `sh_kind` = 0 (logical left), for an amount n from 1 to 31 the result is `rm_val` shifted left with zero fill, and the carry is `rm_val[32-n]`. For n = 32 the result is 0 and the carry is `rm_val[0]`. For n > 32 both the result and the carry are 0.
- R4: With `sh_kind` = 1 (logical right), for n from 1 to 31 the result has zero fill and the carry is `rm_val[n-1]`. For n = 32 the result is 0 and the carry is `rm_val[31]`. For n > 32 both the result and the carry are 0.
- R5: With `sh_kind` = 2 (arithmetic right), the vacated upper bits copy `rm_val[31]`. For n from 1 to 31 the carry is `rm_val[n-1]`. For n ≥ 32 every bit of the result, and the carry, equal `rm_val[31]`.
- R6: With `sh_kind` = 3 (rotate right), bits leaving at bit 0 re-enter at bit 31 and the rotation is by n mod 32. When n is a nonzero multiple of 32, the result equals `rm_val` and the carry is `rm_val[31]`.
- R7: With `sh_kind` = 4 to 7 (rotate right through carry), the result is {`carry_in`, `rm_val[31:1]`} and `carry_out` is `rm_val[0]`. The amount has no effect.
- R8: When `amt_from_reg` = 1 the amount is `rs_val[7:0]` and `rs_val[31:8]` has no effect. When `amt_from_reg` = 0 the amount is `sh_imm` (0 to 31) and `rs_val` has no effect.
- R9: In the shifted mode with `sh_kind` 0 to 3, an amount of zero gives `operand_out` = `rm_val` and `carry_out` = `carry_in`.
- R10: In the shifted mode with `sh_kind` 0 to 3 and a nonzero amount, `carry_out` is the last bit shifted out of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_mode | input | 2 | Operand mode: 0 rotated immediate, 1 or 3 plain register, 2 shifted register |
| sh_kind | input | 3 | Shift kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4-7 rotate through carry |
| amt_from_reg | input | 1 | 1: amount from `rs_val[7:0]`; 0: amount from `sh_imm` |
| imm_val | input | 8 | Constant byte for the immediate mode |
| imm_rot | input | 4 | Half the right-rotation applied to `imm_val` |
| sh_imm | input | 5 | Immediate shift amount |
| rm_val | input | 32 | Register value that is passed through or shifted |
| rs_val | input | 32 | Register holding the shift amount |
| carry_in | input | 1 | Incoming carry flag |
| operand_out | output | 32 | Second operand for the ALU |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The unit has no registers, so both `operand_out` and `carry_out` are due in the same cycle as the inputs that produce them. The bench drives each input set just after a rising clock edge and samples the two outputs at the next falling edge, half a period later, when the combinational paths have long settled. It sweeps every shift kind, both amount sources, both carry values and the boundary amounts 0, 1, 31, 32, 33 and above, together with all sixteen immediate rotations. Each result is compared with a bit-serial reference that moves one position per step.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

   // operand source selection
   typedef enum logic [1:0] {
      MODE_IMM   = 2'd0,
      MODE_REG   = 2'd1,
      MODE_SHIFT = 2'd2,
      MODE_REG_B = 2'd3
   } opnd_mode_e;

   // shift kind; codes 4..7 all mean rotate-through-carry
   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   function automatic logic is_rrx(input logic [2:0] kind);
      return kind[2];
   endfunction

endpackage

// File: rtl/opnd_rotr.sv
// Logarithmic right-rotator: one stage per amount bit.
module opnd_rotr #(
   parameter int W  = 32,
   parameter int SW = 5
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);

   logic [W-1:0] stg [0:SW];

   assign stg[0] = din;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stg[s+1] = amt[s] ? {stg[s][STEP-1:0], stg[s][W-1:STEP]} : stg[s];
   end

   assign dout = stg[SW];

endmodule

// File: rtl/opnd_imm_rot.sv
// Rotated-constant generator: zero-extended byte rotated right by 2*rot.
module opnd_imm_rot #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic [IMM_W-1:0]  imm_val,
   input  logic [ROT_W-1:0]  imm_rot,
   input  logic              carry_in,
   output logic [DATA_W-1:0] imm_out,
   output logic              imm_carry
);

   localparam int RA_W = ROT_W + 1;

   logic [DATA_W-1:0] ext;
   logic [RA_W-1:0]   ramt;

   assign ext  = {{(DATA_W-IMM_W){1'b0}}, imm_val};
   assign ramt = {imm_rot, 1'b0};

   opnd_rotr #(.W(DATA_W), .SW(RA_W)) u_rot (
      .din  (ext),
      .amt  (ramt),
      .dout (imm_out)
   );

   assign imm_carry = (imm_rot == '0) ? carry_in : imm_out[DATA_W-1];

endmodule

// File: rtl/opnd_amt_sel.sv
// Shift amount source: immediate field or low byte of a register.
module opnd_amt_sel #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5,
   parameter int RAMT_W  = 8
) (
   input  logic              amt_from_reg,
   input  logic [SHAMT_W-1:0] sh_imm,
   input  logic [DATA_W-1:0] rs_val,
   output logic [RAMT_W-1:0] amt
);

   logic unused_rs_hi;
   assign unused_rs_hi = ^rs_val[DATA_W-1:RAMT_W];

   assign amt = amt_from_reg ? rs_val[RAMT_W-1:0]
                             : {{(RAMT_W-SHAMT_W){1'b0}}, sh_imm};

endmodule

// File: rtl/opnd_barrel.sv
// Shift core for the shifted-register mode.
module opnd_barrel
   import opnd_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5,
   parameter int RAMT_W  = 8
) (
   input  logic [DATA_W-1:0] val,
   input  logic [2:0]        kind,
   input  logic [RAMT_W-1:0] amt,
   input  logic              carry_in,
   output logic [DATA_W-1:0] res,
   output logic              carry_out
);

   logic [SHAMT_W-1:0] low;
   logic               big;
   logic               eq_w;
   logic               zero;
   logic [DATA_W-1:0]  rot;
   logic [SHAMT_W-1:0] lsl_idx;
   logic [SHAMT_W-1:0] rsh_idx;

   assign low  = amt[SHAMT_W-1:0];
   assign big  = (amt[RAMT_W-1:SHAMT_W] != '0);
   assign eq_w = (amt == RAMT_W'(DATA_W));
   assign zero = (amt == '0);

   assign lsl_idx = SHAMT_W'(DATA_W - int'(low));
   assign rsh_idx = SHAMT_W'(int'(low) - 1);

   opnd_rotr #(.W(DATA_W), .SW(SHAMT_W)) u_rot (
      .din  (val),
      .amt  (low),
      .dout (rot)
   );

   always_comb begin
      res       = val;
      carry_out = carry_in;
      if (is_rrx(kind)) begin
         res       = {carry_in, val[DATA_W-1:1]};
         carry_out = val[0];
      end else if (!zero) begin
         unique case (kind[1:0])
            2'd0: begin
               if (big) begin
                  res       = '0;
                  carry_out = eq_w ? val[0] : 1'b0;
               end else begin
                  res       = val << low;
                  carry_out = val[lsl_idx];
               end
            end
            2'd1: begin
               if (big) begin
                  res       = '0;
                  carry_out = eq_w ? val[DATA_W-1] : 1'b0;
               end else begin
                  res       = val >> low;
                  carry_out = val[rsh_idx];
               end
            end
            2'd2: begin
               if (big) begin
                  res       = {DATA_W{val[DATA_W-1]}};
                  carry_out = val[DATA_W-1];
               end else begin
                  res       = $unsigned($signed(val) >>> low);
                  carry_out = val[rsh_idx];
               end
            end
            default: begin
               res       = rot;
               carry_out = rot[DATA_W-1];
            end
         endcase
      end
   end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
   import opnd_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 8,
   parameter int ROT_W   = 4,
   parameter int SHAMT_W = 5,
   parameter int RAMT_W  = 8
) (
   input  logic [1:0]         op_mode,
   input  logic [2:0]         sh_kind,
   input  logic               amt_from_reg,
   input  logic [IMM_W-1:0]   imm_val,
   input  logic [ROT_W-1:0]   imm_rot,
   input  logic [SHAMT_W-1:0] sh_imm,
   input  logic [DATA_W-1:0]  rm_val,
   input  logic [DATA_W-1:0]  rs_val,
   input  logic               carry_in,
   output logic [DATA_W-1:0]  operand_out,
   output logic               carry_out
);

   // elaboration-time parameter checks
   if (DATA_W != (1 << SHAMT_W)) begin : g_bad_shamt
      $error("DATA_W must equal 2**SHAMT_W");
   end
   if (IMM_W >= DATA_W) begin : g_bad_imm
      $error("IMM_W must be narrower than DATA_W");
   end
   if (ROT_W + 1 > SHAMT_W) begin : g_bad_rot
      $error("doubled rotate field must fit the shift amount width");
   end
   if (RAMT_W <= SHAMT_W || RAMT_W > DATA_W) begin : g_bad_ramt
      $error("RAMT_W must lie between SHAMT_W and DATA_W");
   end

   logic [DATA_W-1:0] imm_res;
   logic              imm_c;
   logic [RAMT_W-1:0] amt;
   logic [DATA_W-1:0] sh_res;
   logic              sh_c;

   opnd_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
      .imm_val   (imm_val),
      .imm_rot   (imm_rot),
      .carry_in  (carry_in),
      .imm_out   (imm_res),
      .imm_carry (imm_c)
   );

   opnd_amt_sel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .RAMT_W(RAMT_W)) u_amt (
      .amt_from_reg (amt_from_reg),
      .sh_imm       (sh_imm),
      .rs_val       (rs_val),
      .amt          (amt)
   );

   opnd_barrel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .RAMT_W(RAMT_W)) u_sh (
      .val       (rm_val),
      .kind      (sh_kind),
      .amt       (amt),
      .carry_in  (carry_in),
      .res       (sh_res),
      .carry_out (sh_c)
   );

   always_comb begin
      unique case (opnd_mode_e'(op_mode))
         MODE_IMM: begin
            operand_out = imm_res;
            carry_out   = imm_c;
         end
         MODE_SHIFT: begin
            operand_out = sh_res;
            carry_out   = sh_c;
         end
         default: begin
            operand_out = rm_val;
            carry_out   = carry_in;
         end
      endcase
   end

endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 8,
   parameter int ROT_W   = 4,
   parameter int SHAMT_W = 5,
   parameter int RAMT_W  = 8
) (
   input logic [1:0]         op_mode,
   input logic [2:0]         sh_kind,
   input logic               amt_from_reg,
   input logic [IMM_W-1:0]   imm_val,
   input logic [ROT_W-1:0]   imm_rot,
   input logic [SHAMT_W-1:0] sh_imm,
   input logic [DATA_W-1:0]  rm_val,
   input logic [DATA_W-1:0]  rs_val,
   input logic               carry_in,
   input logic [DATA_W-1:0]  operand_out,
   input logic               carry_out
);

   logic [RAMT_W-1:0] n;
   logic              shifted;

   always_comb begin
      n       = amt_from_reg ? rs_val[RAMT_W-1:0] : RAMT_W'(sh_imm);
      shifted = (op_mode == 2'd2);

      a_r2_plain_pass: assert (!(op_mode == 2'd1 || op_mode == 2'd3) ||
                               (operand_out == rm_val && carry_out == carry_in))
         else $error("plain register mode altered the operand");

      a_r1_imm_norot: assert (!(op_mode == 2'd0 && imm_rot == '0) ||
                              (operand_out == DATA_W'(imm_val) && carry_out == carry_in))
         else $error("unrotated immediate mismatch");

      a_r1_imm_carry: assert (!(op_mode == 2'd0 && imm_rot != '0) ||
                              (carry_out == operand_out[DATA_W-1]))
         else $error("rotated immediate carry is not bit 31");

      a_r7_rrx: assert (!(shifted && sh_kind[2]) ||
                        (operand_out == {carry_in, rm_val[DATA_W-1:1]} && carry_out == rm_val[0]))
         else $error("rotate through carry mismatch");

      a_r9_zero_amt: assert (!(shifted && !sh_kind[2] && n == '0) ||
                             (operand_out == rm_val && carry_out == carry_in))
         else $error("zero amount changed the operand");

      a_r3_r4_beyond: assert (!(shifted && sh_kind[2:1] == 2'b00 && n > RAMT_W'(DATA_W)) ||
                              (operand_out == '0 && carry_out == 1'b0))
         else $error("logical shift beyond width not cleared");

      a_r5_asr_fill: assert (!(shifted && sh_kind == 3'd2 && n >= RAMT_W'(DATA_W)) ||
                             (operand_out == {DATA_W{rm_val[DATA_W-1]}} &&
                              carry_out == rm_val[DATA_W-1]))
         else $error("arithmetic shift beyond width not sign filled");

      a_r6_ror_wrap: assert (!(shifted && sh_kind == 3'd3 && n != '0 &&
                               n[SHAMT_W-1:0] == '0) ||
                             (operand_out == rm_val && carry_out == rm_val[DATA_W-1]))
         else $error("rotate by multiple of width mismatch");
   end

endmodule

bind opnd_shifter opnd_shifter_chk #(
   .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .SHAMT_W(SHAMT_W), .RAMT_W(RAMT_W)
) u_chk (.*);

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;

   logic        clk = 1'b0;
   logic [1:0]  op_mode = '0;
   logic [2:0]  sh_kind = '0;
   logic        amt_from_reg = 1'b0;
   logic [7:0]  imm_val = '0;
   logic [3:0]  imm_rot = '0;
   logic [4:0]  sh_imm = '0;
   logic [31:0] rm_val = '0;
   logic [31:0] rs_val = '0;
   logic        carry_in = 1'b0;
   logic [31:0] operand_out;
   logic        carry_out;

   int total = 0;
   int bad   = 0;
   logic done = 1'b0;

   // 20 ns period: 50 MHz
   always #10 clk = ~clk;

   opnd_shifter u_dut (
      .op_mode      (op_mode),
      .sh_kind      (sh_kind),
      .amt_from_reg (amt_from_reg),
      .imm_val      (imm_val),
      .imm_rot      (imm_rot),
      .sh_imm       (sh_imm),
      .rm_val       (rm_val),
      .rs_val       (rs_val),
      .carry_in     (carry_in),
      .operand_out  (operand_out),
      .carry_out    (carry_out)
   );

   // bit-serial reference: one position per step
   function automatic logic [32:0] ref_shift(input logic [31:0] v, input int k,
                                             input int n, input logic c);
      logic [31:0] x = v;
      logic        co = c;
      if (k >= 4) return {v[0], c, v[31:1]};
      for (int i = 0; i < n; i++) begin
         case (k)
            0: begin co = x[31]; x = {x[30:0], 1'b0}; end
            1: begin co = x[0];  x = {1'b0, x[31:1]}; end
            2: begin co = x[0];  x = {x[31], x[31:1]}; end
            default: begin co = x[0]; x = {x[0], x[31:1]}; end
         endcase
      end
      return {co, x};
   endfunction

   function automatic string req_of(input int k, input int n);
      if (k >= 4) return "R7";
      if (n == 0) return "R9";
      case (k)
         0: return "R3/R10";
         1: return "R4/R10";
         2: return "R5/R10";
         default: return "R6/R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] exp_v, input logic exp_c);
      @(negedge clk);
      total++;
      if (operand_out !== exp_v || carry_out !== exp_c) begin
         bad++;
         $display("FAIL %s: got %h/%b expected %h/%b", req, operand_out, carry_out,
                  exp_v, exp_c);
      end
   endtask

   initial begin
      logic [31:0] vals [6];
      int          amts [12];
      logic [32:0] e;
      vals = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678,
               32'h7FFF_FFFE, 32'hA5C3_0F96};
      amts = '{0, 1, 2, 15, 31, 32, 33, 63, 64, 96, 200, 255};

      // quiescent state: all inputs zero, immediate mode
      @(posedge clk);
      check("R1", 32'h0, 1'b0);

      // R1: every rotation of several constants, both carry values
      for (int r = 0; r < 16; r++) begin
         for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 2; c++) begin
               logic [7:0] iv;
               iv = (b == 0) ? 8'h01 : (b == 1) ? 8'hFF : (b == 2) ? 8'h80 : 8'h5A;
               @(posedge clk);
               op_mode = 2'd0; imm_val = iv; imm_rot = 4'(r); carry_in = c[0];
               rm_val = $urandom; rs_val = $urandom;
               e = ref_shift({24'h0, iv}, 3, 2 * r, c[0]);
               check("R1", e[31:0], (r == 0) ? c[0] : e[31]);
            end
         end
      end

      // R2: plain register modes 1 and 3, shift controls do nothing
      for (int m = 1; m < 4; m += 2) begin
         for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            op_mode = 2'(m); rm_val = vals[i]; sh_kind = 3'(i);
            rs_val = $urandom; sh_imm = 5'(i * 7); carry_in = i[0];
            check("R2", vals[i], i[0]);
         end
      end

      // R3..R10: all kinds, both amount sources, edge amounts, both carries
      for (int k = 0; k < 8; k++) begin
         for (int src = 0; src < 2; src++) begin
            for (int a = 0; a < 12; a++) begin
               for (int i = 0; i < 6; i++) begin
                  for (int c = 0; c < 2; c++) begin
                     int n;
                     logic [31:0] rsv;
                     n = (src == 1) ? amts[a] : (amts[a] % 32);
                     @(posedge clk);
                     op_mode = 2'd2; sh_kind = 3'(k); amt_from_reg = src[0];
                     rm_val = vals[i]; carry_in = c[0];
                     imm_val = $urandom; imm_rot = $urandom;
                     rsv = $urandom;
                     if (src == 1) begin
                        // R8: upper bits of the amount register are noise
                        rs_val = {rsv[31:8], 8'(amts[a])};
                        sh_imm = 5'(rsv);
                     end else begin
                        rs_val = rsv;
                        sh_imm = 5'(n);
                     end
                     e = ref_shift(vals[i], (k >= 4) ? 4 : k, n, c[0]);
                     check({req_of(k, n), "/R8"}, e[31:0], e[32]);
                  end
               end
            end
         end
      end

      // R7: amount does not matter for rotate through carry
      for (int a = 0; a < 12; a++) begin
         @(posedge clk);
         op_mode = 2'd2; sh_kind = 3'd4; amt_from_reg = 1'b1;
         rs_val = 32'(amts[a]); rm_val = 32'hC000_0003; carry_in = a[0];
         check("R7", {a[0], 31'h6000_0001}, 1'b1);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule